// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command decoder of a serial NOR flash model. It runs on a system clock. It samples chip select, the serial clock and the serial data input as ordinary synchronous inputs, and it assembles the opcode, the 24-bit address and any data bytes on each rising serial-clock edge. It keeps a write-enable latch, a deep power-down flag and a busy timer. Whether a program, erase or sector-protection command is committed is decided only when chip select rises.

Before it commits a program or erase, the block shows the address it collected and the kind of command it decoded to an external protection checker, and it reads back a one-bit protected answer. A committed command appears as a one-cycle strobe. The strobe carries the command kind, the address aligned to the command's granule and, for a program, the number of data bytes it kept. The block then reports busy for a fixed number of system clock cycles. The memory array and the real write timing sit outside the block.

Top module: `spiFlashFront`

## Requirements
- R1: Serial input is captured on the rising serial-clock edge, most significant bit first. Chip select may fall with the serial clock idle low (mode 0) or idle high (mode 3), and both give the same result.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. After opcode 05h, each following byte on `miso` is the status byte, most significant bit first. Bit 1 of that byte is the latch, bit 0 is busy, and bits 7..2 are zero. `miso` is 0 whenever chip select is high.
- R3: A modifying command commits only when chip select rises after a whole number of bytes. If it rises part-way through a byte, nothing commits and the latch is cleared.
- R4: Opcodes 20h, 52h and D8h commit erase kinds 2, 3 and 4. The committed address has its low 12, 15 and 16 bits cleared.
- R5: Opcode 02h commits program kind 1 with the full start address. The committed count is the number of data bytes, capped at 256. A program with no data byte does not commit.
- R6: No modifying command commits while the write-enable latch is clear.
- R7: A program or erase whose address lies in a sector reported as protected does not commit.
- R8: Every modifying command (kinds 1 to 6) clears the write-enable latch, whether it commits or not.
- R9: After a commit, busy stays high for exactly BUSY_CYCLES clock cycles. While busy, every command except the status read has no effect.
- R10: Opcode B9h enters deep power-down, but only while not busy. In deep power-down only opcode ABh has an effect, and it leaves the mode.
- R11: If chip select rises while the hold input is low, the command is aborted and the latch is cleared.
- R12: Reads (03h, and 0Bh with its dummy byte) change no state, even when chip select rises in the middle of a bit count.
- R13: Opcodes 36h and 39h commit protect kind 5 and unprotect kind 6 on the 64-Kbyte sector address. They need the latch, and a protected answer does not block them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| holdN | input | 1 | Hold, active low |
| miso | output | 1 | Serial data out (status byte) |
| cmdKind | output | 3 | Kind of the decoded opcode, 0 if it is not a modifying command |
| cmdAddr | output | ADDR_W | Address collected so far, for the protection checker |
| sectProt | input | 1 | Protection checker answer for `cmdAddr` |
| commitStb | output | 1 | One-cycle commit strobe |
| commitKind | output | 3 | Kind of the committed command |
| commitAddr | output | ADDR_W | Committed address, aligned to the granule |
| commitCount | output | LEN_W | Data bytes kept by a program |
| busy | output | 1 | Internal operation in progress |
| wel | output | 1 | Write-enable latch |
| deepPd | output | 1 | Deep power-down state |

## Verification
The inputs pass through one register stage for edge detection. A serial-clock rise is therefore counted at the first system clock edge that sees it, and a chip-select rise updates `wel`, `deepPd`, `commitStb` and the busy timer at that same edge. The reference model in the bench updates at the same posedge from the bench's own view of the pins and the bytes it sent. The bench compares the model with the outputs at every falling clock edge, half a cycle after any change. `miso` is sampled two system cycles into the low phase of each serial-clock bit, after the bit counter has settled. Busy is then expected to stay high for exactly BUSY_CYCLES clocks.

// File: rtl/spiFlashPkg.sv
package spiFlashPkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_ER4K   = 8'h20;
  localparam logic [7:0] OP_ER32K  = 8'h52;
  localparam logic [7:0] OP_ER64K  = 8'hD8;
  localparam logic [7:0] OP_PROT   = 8'h36;
  localparam logic [7:0] OP_UNPROT = 8'h39;
  localparam logic [7:0] OP_DPD    = 8'hB9;
  localparam logic [7:0] OP_WAKE   = 8'hAB;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_PROG   = 3'd1,
    KIND_ER4K   = 3'd2,
    KIND_ER32K  = 3'd3,
    KIND_ER64K  = 3'd4,
    KIND_PROT   = 3'd5,
    KIND_UNPROT = 3'd6
  } kind_e;

  // strobes from the control decision to the datapath state
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic commit;
    logic enterDeep;
    logic leaveDeep;
  } strobe_t;

  function automatic kind_e kindOf(input logic [7:0] op);
    case (op)
      OP_PROG:   return KIND_PROG;
      OP_ER4K:   return KIND_ER4K;
      OP_ER32K:  return KIND_ER32K;
      OP_ER64K:  return KIND_ER64K;
      OP_PROT:   return KIND_PROT;
      OP_UNPROT: return KIND_UNPROT;
      default:   return KIND_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spiFlashCtl.sv
module spiFlashCtl
  import spiFlashPkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 10
) (
  input  logic             csRise,
  input  logic             holdN,
  input  logic [7:0]       opcode,
  input  logic [2:0]       bitCnt,
  input  logic [CNT_W-1:0] byteCnt,
  input  logic             wel,
  input  logic             busy,
  input  logic             deep,
  input  logic             sectProt,
  output strobe_t          strb
);
  localparam logic [CNT_W-1:0] MIN_ADDR_LEN = CNT_W'(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] MIN_PROG_LEN = CNT_W'(ADDR_BYTES + 2);

  kind_e kind;
  logic  aligned, hasOp, lenOk, needProt;

  always_comb begin
    kind     = kindOf(opcode);
    aligned  = (bitCnt == 3'd0);
    hasOp    = (byteCnt != '0);
    lenOk    = (kind == KIND_PROG) ? (byteCnt >= MIN_PROG_LEN) : (byteCnt >= MIN_ADDR_LEN);
    needProt = (kind == KIND_PROG) || (kind == KIND_ER4K) ||
               (kind == KIND_ER32K) || (kind == KIND_ER64K);
    strb = '0;
    if (csRise) begin
      if (!holdN) begin
        strb.clrWel = 1'b1;
      end else if (!busy && hasOp) begin
        if (deep) begin
          strb.leaveDeep = aligned && (opcode == OP_WAKE);
        end else if (kind != KIND_NONE) begin
          strb.clrWel = 1'b1;
          strb.commit = wel && aligned && lenOk && !(needProt && sectProt);
        end else if (aligned) begin
          strb.setWel    = (opcode == OP_WREN);
          strb.clrWel    = (opcode == OP_WRDI);
          strb.enterDeep = (opcode == OP_DPD);
        end
      end
    end
  end
endmodule

// File: rtl/spiFlashDp.sv
module spiFlashDp
  import spiFlashPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 10,
  parameter int PAGE_BYTES  = 256,
  parameter int BUSY_CYCLES = 64,
  parameter int SHIFT_SMALL = 12,
  parameter int SHIFT_MID   = 15,
  parameter int SHIFT_SECT  = 16,
  localparam int LEN_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              holdN,
  input  strobe_t           strb,
  output logic              csRise,
  output logic [7:0]        opcode,
  output logic [2:0]        bitCnt,
  output logic [CNT_W-1:0]  byteCnt,
  output logic [ADDR_W-1:0] addrReg,
  output logic              wel,
  output logic              busy,
  output logic              deep,
  output logic              miso,
  output logic              commitStb,
  output logic [2:0]        commitKind,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [LEN_W-1:0]  commitCount
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int BUSY_W     = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W-1:0] MASK_SMALL = ~((ADDR_W'(1) << SHIFT_SMALL) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] MASK_MID   = ~((ADDR_W'(1) << SHIFT_MID) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] MASK_SECT  = ~((ADDR_W'(1) << SHIFT_SECT) - ADDR_W'(1));

  logic              sckPrev, csPrev, sckRise;
  logic [6:0]        shiftReg;
  logic [7:0]        byteNext, statusByte;
  logic [BUSY_W-1:0] busyCnt;
  logic [CNT_W-1:0]  dataBytes;
  logic [ADDR_W-1:0] alignedAddr;
  logic [LEN_W-1:0]  keptBytes;

  assign sckRise    = sck & ~sckPrev;
  assign csRise     = csN & ~csPrev;
  assign byteNext   = {shiftReg, mosi};
  assign busy       = (busyCnt != '0);
  assign statusByte = {6'b0, wel, busy};
  assign miso       = !csN && !deep && (opcode == OP_RDSR) && (byteCnt != '0) ? statusByte[~bitCnt] : 1'b0;
  assign dataBytes  = byteCnt - CNT_W'(ADDR_BYTES + 1);
  assign keptBytes  = (dataBytes > CNT_W'(PAGE_BYTES)) ? LEN_W'(PAGE_BYTES) : LEN_W'(dataBytes);

  always_comb begin
    case (kindOf(opcode))
      KIND_ER4K:  alignedAddr = addrReg & MASK_SMALL;
      KIND_ER32K: alignedAddr = addrReg & MASK_MID;
      KIND_PROG:  alignedAddr = addrReg;
      default:    alignedAddr = addrReg & MASK_SECT;
    endcase
  end

  // serial capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      csPrev   <= 1'b1;
      shiftReg <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      opcode   <= '0;
      addrReg  <= '0;
    end else begin
      sckPrev <= sck;
      csPrev  <= csN;
      if (csN) begin
        bitCnt  <= '0;
        byteCnt <= '0;
        opcode  <= '0;
      end else if (sckRise && holdN) begin
        shiftReg <= byteNext[6:0];
        bitCnt   <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (byteCnt == '0) opcode <= byteNext;
          else if (byteCnt <= CNT_W'(ADDR_BYTES)) addrReg <= {addrReg[ADDR_W-9:0], byteNext};
          if (~&byteCnt) byteCnt <= byteCnt + 1'b1;
        end
      end
    end
  end

  // device state and commit record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel         <= 1'b0;
      deep        <= 1'b0;
      busyCnt     <= '0;
      commitStb   <= 1'b0;
      commitKind  <= '0;
      commitAddr  <= '0;
      commitCount <= '0;
    end else begin
      if (strb.setWel) wel <= 1'b1;
      else if (strb.clrWel) wel <= 1'b0;
      if (strb.enterDeep) deep <= 1'b1;
      else if (strb.leaveDeep) deep <= 1'b0;
      if (strb.commit) busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
      commitStb <= strb.commit;
      if (strb.commit) begin
        commitKind  <= kindOf(opcode);
        commitAddr  <= alignedAddr;
        commitCount <= (kindOf(opcode) == KIND_PROG) ? keptBytes : '0;
      end
    end
  end
endmodule

// File: rtl/spiFlashFront.sv
module spiFlashFront
  import spiFlashPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 10,
  parameter int PAGE_BYTES  = 256,
  parameter int BUSY_CYCLES = 64,
  parameter int SHIFT_SMALL = 12,
  parameter int SHIFT_MID   = 15,
  parameter int SHIFT_SECT  = 16,
  localparam int LEN_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              holdN,
  output logic              miso,
  output logic [2:0]        cmdKind,
  output logic [ADDR_W-1:0] cmdAddr,
  input  logic              sectProt,
  output logic              commitStb,
  output logic [2:0]        commitKind,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [LEN_W-1:0]  commitCount,
  output logic              busy,
  output logic              wel,
  output logic              deepPd
);
  strobe_t          strb;
  logic             csRise;
  logic [7:0]       opcode;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] byteCnt;

  assign cmdKind = kindOf(opcode);

  spiFlashDp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES),
    .SHIFT_SMALL(SHIFT_SMALL), .SHIFT_MID(SHIFT_MID), .SHIFT_SECT(SHIFT_SECT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .holdN(holdN),
    .strb(strb), .csRise(csRise), .opcode(opcode), .bitCnt(bitCnt), .byteCnt(byteCnt),
    .addrReg(cmdAddr), .wel(wel), .busy(busy), .deep(deepPd), .miso(miso),
    .commitStb(commitStb), .commitKind(commitKind), .commitAddr(commitAddr),
    .commitCount(commitCount)
  );

  spiFlashCtl #(.ADDR_BYTES(ADDR_W / 8), .CNT_W(CNT_W)) ctl_i (
    .csRise(csRise), .holdN(holdN), .opcode(opcode), .bitCnt(bitCnt), .byteCnt(byteCnt),
    .wel(wel), .busy(busy), .deep(deepPd), .sectProt(sectProt), .strb(strb)
  );
endmodule

// File: rtl/spiFlashFrontChk.sv
module spiFlashFrontChk #(
  parameter int SHIFT_SMALL = 12,
  parameter int LEN_W       = 9,
  parameter int PAGE_BYTES  = 256
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   csN,
  input logic                   holdN,
  input logic                   miso,
  input logic                   sectProt,
  input logic                   commitStb,
  input logic [2:0]             commitKind,
  input logic [SHIFT_SMALL-1:0] addrLow,
  input logic [LEN_W-1:0]       commitCount,
  input logic                   busy,
  input logic                   wel,
  input logic                   deepPd
);
  p_commit_starts_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> busy);
  p_commit_drops_wel_r8: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !wel);
  p_commit_needs_wel_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> $past(wel));
  p_commit_on_cs_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> $past(csN && holdN));
  p_erase_small_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && commitKind == 3'd2) |-> (addrLow == '0));
  p_protected_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && commitKind >= 3'd1 && commitKind <= 3'd4) |-> !$past(sectProt));
  p_prog_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (commitStb && commitKind == 3'd1) |-> (commitCount != '0 && commitCount <= LEN_W'(PAGE_BYTES)));
  p_deep_not_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    deepPd |-> !busy);
  p_miso_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !miso);
endmodule

bind spiFlashFront spiFlashFrontChk #(
  .SHIFT_SMALL(SHIFT_SMALL), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .holdN(holdN), .miso(miso), .sectProt(sectProt),
  .commitStb(commitStb), .commitKind(commitKind), .addrLow(commitAddr[SHIFT_SMALL-1:0]),
  .commitCount(commitCount), .busy(busy), .wel(wel), .deepPd(deepPd)
);

// File: tb/spiFlashFront_tb_top.sv
module spiFlashFront_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 300;

  logic clk = 0, rstN = 0, csN = 1, sck = 0, mosi = 0, holdN = 1;
  logic miso, commitStb, busy, wel, deepPd, sectProt;
  logic [2:0] cmdKind, commitKind;
  logic [23:0] cmdAddr, commitAddr;
  logic [8:0] commitCount;
  logic [255:0] protMap = '0;

  assign sectProt = protMap[cmdAddr[23:16]];
  always #(CLK_PERIOD / 2) clk = ~clk;

  spiFlashFront #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .holdN(holdN), .miso(miso),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .sectProt(sectProt), .commitStb(commitStb),
    .commitKind(commitKind), .commitAddr(commitAddr), .commitCount(commitCount),
    .busy(busy), .wel(wel), .deepPd(deepPd)
  );

  int checks = 0, fails = 0;
  string curReq = "R1";

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int nBits = 0;
  logic [7:0] curByte = 0;
  logic [7:0] byteQ[$];
  bit mWel = 0, mDeep = 0, mCommit = 0, mCsPrev = 1, running = 0;
  int mBusy = 0, mKind = 0, mCount = 0;
  logic [23:0] mAddr = 0;

  function automatic int kindNum(logic [7:0] op);
    case (op)
      8'h02: return 1; 8'h20: return 2; 8'h52: return 3; 8'hD8: return 4;
      8'h36: return 5; 8'h39: return 6; default: return 0;
    endcase
  endfunction

  task automatic evalRise(bit wasBusy);
    int nB = byteQ.size();
    bit al = (nBits % 8) == 0;
    logic [7:0] op = (nB > 0) ? byteQ[0] : 8'h00;
    logic [23:0] a = (nB >= 4) ? {byteQ[1], byteQ[2], byteQ[3]} : 24'h0;
    int k = kindNum(op);
    if (!holdN) mWel = 0;
    else if (!wasBusy && nB > 0) begin
      if (mDeep) begin
        if (op == 8'hAB && al) mDeep = 0;
      end else if (k != 0) begin
        bit wasWel = mWel;
        bit lenOk = (k == 1) ? (nB >= 5) : (nB >= 4);
        bit blocked = (k <= 4) && protMap[a[23:16]];
        mWel = 0;
        if (wasWel && al && lenOk && !blocked) begin
          mCommit = 1; mKind = k; mBusy = BUSY;
          case (k)
            1: mAddr = a;
            2: mAddr = a & 24'hFFF000;
            3: mAddr = a & 24'hFF8000;
            default: mAddr = a & 24'hFF0000;
          endcase
          mCount = (k == 1) ? (((nB - 4) > 256) ? 256 : (nB - 4)) : 0;
        end
      end else if (al) begin
        if (op == 8'h06) mWel = 1;
        if (op == 8'h04) mWel = 0;
        if (op == 8'hB9) mDeep = 1;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mWel = 0; mDeep = 0; mBusy = 0; mCommit = 0; mCsPrev = 1;
    end else begin
      bit wasBusy;
      wasBusy = mBusy > 0;
      mCommit = 0;
      if (mBusy > 0) mBusy--;
      if (csN && !mCsPrev) evalRise(wasBusy);
      mCsPrev = csN;
    end
  end

  int commitSeen = 0;
  int lastKind = 0, lastCount = 0;
  logic [23:0] lastAddr = 0;

  always @(negedge clk) begin
    if (rstN && running) begin
      chk(curReq, "wel", wel, mWel);
      chk(curReq, "busy", busy, mBusy > 0);
      chk(curReq, "deepPd", deepPd, mDeep);
      chk(curReq, "commitStb", commitStb, mCommit);
      if (mCommit) begin
        chk(curReq, "commitKind", commitKind, mKind);
        chk(curReq, "commitAddr", commitAddr, mAddr);
        chk(curReq, "commitCount", commitCount, mCount);
      end
    end
    if (commitStb) begin
      commitSeen++; lastKind = commitKind; lastAddr = commitAddr; lastCount = commitCount;
    end
  end

  // ---------------- stimulus ----------------
  logic sampledMiso;
  logic [7:0] sampExp;

  task automatic spiBit(bit b);
    @(negedge clk); sck = 0; mosi = b;
    @(negedge clk); @(negedge clk);
    sampledMiso = miso;
    sampExp = {6'b0, mWel, mBusy > 0};
    sck = 1;
    if (!csN && holdN) begin
      curByte = {curByte[6:0], b};
      nBits++;
      if (nBits % 8 == 0) byteQ.push_back(curByte);
    end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic sendByte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) spiBit(v[i]);
  endtask

  task automatic csLow(bit mode3);
    @(negedge clk); sck = mode3;
    nBits = 0; byteQ.delete(); curByte = 0;
    @(negedge clk); csN = 0;
    @(negedge clk);
  endtask

  task automatic csHigh(bit mode3);
    @(negedge clk); sck = mode3;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(bit mode3, logic [7:0] op, bit hasAddr, logic [23:0] a, int nData);
    csLow(mode3);
    sendByte(op);
    if (hasAddr) begin sendByte(a[23:16]); sendByte(a[15:8]); sendByte(a[7:0]); end
    for (int i = 0; i < nData; i++) sendByte(8'(i * 7 + 1));
    csHigh(mode3);
  endtask

  task automatic rdsr(output logic [7:0] v);
    csLow(0);
    sendByte(8'h05);
    for (int i = 7; i >= 0; i--) begin
      spiBit(0);
      v[i] = sampledMiso;
      chk("R2", "status bit on miso", sampledMiso, sampExp[i]);
    end
    csHigh(0);
  endtask

  task automatic waitReady();
    logic [7:0] st;
    int polls = 0;
    do begin rdsr(st); polls++; end while (st[0] && polls < 50);
    chk("R9", "ready after polling", st[0], 0);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishUp();
  end

  initial begin
    logic [7:0] st;
    int seen;
    protMap[8'h20] = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R2", "reset wel", wel, 0);
    chk("R9", "reset busy", busy, 0);
    chk("R10", "reset deepPd", deepPd, 0);
    chk("R3", "reset commitStb", commitStb, 0);
    chk("R2", "reset miso", miso, 0);
    running = 1;

    curReq = "R1 R2 mode0 WREN";
    cmd(0, 8'h06, 0, 0, 0);
    chk("R1", "wel set via mode 0", wel, 1);
    rdsr(st);
    chk("R2", "status byte", st, 8'h02);
    curReq = "R2 WRDI";
    cmd(0, 8'h04, 0, 0, 0);
    chk("R2", "wel cleared by WRDI", wel, 0);
    curReq = "R1 mode3 WREN";
    cmd(1, 8'h06, 0, 0, 0);
    chk("R1", "wel set via mode 3", wel, 1);

    curReq = "R4 R9 erase 4K";
    seen = commitSeen;
    cmd(0, 8'h20, 1, 24'h123456, 0);
    chk("R4", "erase4k commit", commitSeen - seen, 1);
    chk("R4", "erase4k addr", lastAddr, 24'h123000);
    chk("R4", "erase4k kind", lastKind, 2);
    chk("R9", "busy after commit", busy, 1);
    rdsr(st);
    chk("R9", "status while busy", st, 8'h01);
    cmd(0, 8'h06, 0, 0, 0);
    chk("R9", "WREN ignored while busy", wel, 0);
    waitReady();

    curReq = "R4 erase 32K mode3";
    cmd(1, 8'h06, 0, 0, 0);
    cmd(1, 8'h52, 1, 24'h0ABCDE, 0);
    chk("R4", "erase32k addr", lastAddr, 24'h0A8000);
    chk("R4", "erase32k kind", lastKind, 3);
    waitReady();
    curReq = "R4 erase 64K";
    cmd(0, 8'h06, 0, 0, 0);
    cmd(0, 8'hD8, 1, 24'h3FFFFF, 1);
    chk("R4", "erase64k addr", lastAddr, 24'h3F0000);
    chk("R4", "erase64k kind", lastKind, 4);
    waitReady();

    curReq = "R5 program 3 bytes";
    cmd(0, 8'h06, 0, 0, 0);
    cmd(0, 8'h02, 1, 24'h0010F0, 3);
    chk("R5", "program addr", lastAddr, 24'h0010F0);
    chk("R5", "program count", lastCount, 3);
    chk("R5", "program kind", lastKind, 1);
    waitReady();
    curReq = "R5 program 300 bytes";
    cmd(0, 8'h06, 0, 0, 0);
    cmd(0, 8'h02, 1, 24'h000080, 300);
    chk("R5", "program count capped", lastCount, 256);
    waitReady();
    curReq = "R5 program no data";
    cmd(0, 8'h06, 0, 0, 0);
    seen = commitSeen;
    cmd(0, 8'h02, 1, 24'h000100, 0);
    chk("R5", "no commit without data", commitSeen - seen, 0);
    chk("R8", "wel cleared by rejected program", wel, 0);

    curReq = "R6 no WREN";
    seen = commitSeen;
    cmd(0, 8'h20, 1, 24'h001000, 0);
    chk("R6", "no commit without latch", commitSeen - seen, 0);

    curReq = "R3 misaligned erase";
    cmd(0, 8'h06, 0, 0, 0);
    seen = commitSeen;
    csLow(0);
    sendByte(8'h20); sendByte(8'h00); sendByte(8'h10); sendByte(8'h00);
    spiBit(1); spiBit(0); spiBit(1);
    csHigh(0);
    chk("R3", "no commit on partial byte", commitSeen - seen, 0);
    chk("R3", "wel cleared on partial byte", wel, 0);

    curReq = "R7 protected erase";
    cmd(0, 8'h06, 0, 0, 0);
    seen = commitSeen;
    cmd(0, 8'h20, 1, 24'h201000, 0);
    chk("R7", "no commit in protected sector", commitSeen - seen, 0);
    chk("R7", "wel cleared after rejection", wel, 0);
    curReq = "R13 protect sector";
    cmd(0, 8'h06, 0, 0, 0);
    cmd(0, 8'h36, 1, 24'h201234, 0);
    chk("R13", "protect kind", lastKind, 5);
    chk("R13", "protect addr", lastAddr, 24'h200000);
    waitReady();
    curReq = "R13 unprotect sector";
    cmd(0, 8'h06, 0, 0, 0);
    cmd(0, 8'h39, 1, 24'h05FFFF, 0);
    chk("R13", "unprotect kind", lastKind, 6);
    chk("R13", "unprotect addr", lastAddr, 24'h050000);
    waitReady();

    curReq = "R12 reads";
    cmd(0, 8'h06, 0, 0, 0);
    seen = commitSeen;
    csLow(0);
    sendByte(8'h03); sendByte(8'h00); sendByte(8'h20); sendByte(8'h00); sendByte(8'hFF);
    spiBit(1); spiBit(1); spiBit(0);
    csHigh(0);
    csLow(1);
    sendByte(8'h0B); sendByte(8'h01); sendByte(8'h02); sendByte(8'h03); sendByte(8'h00);
    spiBit(0);
    csHigh(1);
    chk("R12", "reads keep wel", wel, 1);
    chk("R12", "reads commit nothing", commitSeen - seen, 0);

    curReq = "R11 hold abort";
    seen = commitSeen;
    csLow(0);
    sendByte(8'h02); sendByte(8'h00); sendByte(8'h30); sendByte(8'h00); sendByte(8'h55);
    @(negedge clk); sck = 0; holdN = 0;
    @(negedge clk); csN = 1;
    repeat (3) @(negedge clk);
    holdN = 1;
    @(negedge clk);
    chk("R11", "no commit under hold", commitSeen - seen, 0);
    chk("R11", "wel cleared by hold abort", wel, 0);

    curReq = "R10 deep power-down";
    cmd(0, 8'h06, 0, 0, 0);
    cmd(0, 8'hD8, 1, 24'h010000, 0);
    cmd(0, 8'hB9, 0, 0, 0);
    chk("R10", "DPD ignored while busy", deepPd, 0);
    waitReady();
    cmd(0, 8'hB9, 0, 0, 0);
    chk("R10", "DPD entered", deepPd, 1);
    cmd(0, 8'h06, 0, 0, 0);
    chk("R10", "WREN ignored in DPD", wel, 0);
    cmd(0, 8'hAB, 0, 0, 0);
    chk("R10", "resume leaves DPD", deepPd, 0);

    repeat (5) @(negedge clk);
    running = 0;
    finishUp();
  end
endmodule